// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the status byte of a small serial flash and decides whether each write command that reaches it may proceed. A command decoder in front of it delivers one-cycle strobes once a command has been fully shifted in and chip select has returned high. The block answers with a one-cycle permission pulse that starts the array engine or its own self-timed status write. It also presents the byte returned by a status read and a strobe that marks the cycle in which new status contents take effect. Array programming and erasing happen elsewhere; the engine reports completion on `array_done_i`.

Three mechanisms gate writes. The first is a write-enable latch that software sets and clears and that clears itself when any write finishes. The second is a two-bit protection level that locks the top quarter, the top half or all of the array. The third is the write-protect pin, which only counts when the protect-enable bit of the status byte is set. The storage that would be nonvolatile in silicon is held in flops.

The control is a three-state machine. `ST_IDLE` accepts commands. `ST_SR_WRITE` runs a self-timed status update of `SR_WR_CYC` cycles. `ST_ARRAY_OP` waits for the array engine. The transitions are:
- accept-status-write: `ST_IDLE` to `ST_SR_WRITE`.
- accept-array-op: `ST_IDLE` to `ST_ARRAY_OP`.
- status-timer-expiry: `ST_SR_WRITE` to `ST_IDLE`.
- array-done: `ST_ARRAY_OP` to `ST_IDLE`.

Top module: `sf_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and `write_ok_o` and `sr_update_o` are low.
- R2: When not busy, the status byte is laid out as follows: bit 7 is protect-enable, bits 6..4 read 0, bits 3:2 are the protection level, bit 1 is the write-enable latch and bit 0 reads 0. While a write is in progress all eight bits read 1.
- R3: When idle, a write-enable strobe sets the latch and a write-disable strobe clears it, whatever the level of `wp_n_i`.
- R4: A program, sector erase, block erase, chip erase or status write strobe with the latch clear is refused. `write_ok_o` stays low and the status byte is unchanged.
- R5: Program, sector erase and block erase are refused when the target address is locked. Level 00 locks nothing. Level 01 locks addresses at or above 3/4 of the array (0x18000 for 17 bits). Level 10 locks at or above 1/2 (0x10000). Level 11 locks everything. A refusal leaves the latch set.
- R6: Chip erase is accepted at levels 00, 01 and 10, and refused at level 11.
- R7: A status write is refused while protect-enable is 1 and `wp_n_i` is 0 when its strobe arrives. With protect-enable 0, a low pin does not block it.
- R8: A status write stores only data bits 7, 3 and 2. The other data bits have no effect on the status byte.
- R9: An accepted status write reads busy for `SR_WR_CYC` cycles after the strobe cycle. The new value and a one-cycle `sr_update_o` appear together in the following cycle, with the latch cleared. A fall of `wp_n_i` during that window does not stop the update.
- R10: An accepted array operation raises `write_ok_o` for exactly one cycle, the cycle after the strobe. The status byte stays busy until `array_done_i`, and the cycle after it reads with the latch clear.
- R11: While busy, every command strobe is ignored. No permission pulse is given and the status contents are not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_wren_i | input | 1 | Write-enable command strobe |
| cmd_wrdi_i | input | 1 | Write-disable command strobe |
| cmd_wrsr_i | input | 1 | Status write command strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| cmd_prog_i | input | 1 | Page program command strobe |
| cmd_sect_erase_i | input | 1 | Sector erase command strobe |
| cmd_blk_erase_i | input | 1 | Block erase command strobe |
| cmd_chip_erase_i | input | 1 | Chip erase command strobe |
| addr_i | input | ADDR_W | Target byte address of program or erase |
| array_done_i | input | 1 | Array engine finished its operation |
| status_o | output | 8 | Byte returned by a status read |
| write_ok_o | output | 1 | One-cycle pulse: command accepted |
| sr_update_o | output | 1 | One-cycle pulse: new status contents in effect |

## Verification
The write-enable latch and busy changes from a strobe show on `status_o` one cycle after the strobe, as does the permission pulse on `write_ok_o`. A status write shows its new contents `SR_WR_CYC` cycles after that, together with `sr_update_o`. Array completion shows one cycle after `array_done_i`. The bench drives each strobe for exactly one clock between two falling edges and samples at the falling edge that follows. It then counts whole clocks to the next due result, checking every intermediate cycle of the status-write window.

// File: rtl/sf_status_pkg.sv
package sf_status_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SR_WRITE = 2'd1,
        ST_ARRAY_OP = 2'd2
    } fsm_state_t;

    // positions that a status read decodes
    localparam int SR_BUSY = 0;
    localparam int SR_WEL  = 1;
    localparam int SR_BP0  = 2;
    localparam int SR_BP1  = 3;
    localparam int SR_WPEN = 7;

    // bits a status write may change
    localparam logic [7:0] SR_WR_MASK = 8'h8C;

endpackage

// File: rtl/sf_prot_check.sv
module sf_prot_check #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        level_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              addr_locked_o,
    output logic              all_locked_o
);
    localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);

    always_comb begin
        unique case (level_i)
            2'b00:   addr_locked_o = 1'b0;
            2'b01:   addr_locked_o = (addr_i >= QUARTER_BASE);
            2'b10:   addr_locked_o = (addr_i >= HALF_BASE);
            default: addr_locked_o = 1'b1;
        endcase
        all_locked_o = (level_i == 2'b11);
    end
endmodule

// File: rtl/sf_sr_bits.sv
module sf_sr_bits
    import sf_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set_i,
    input  logic       wel_clr_i,
    input  logic       load_i,
    input  logic [7:0] load_data_i,
    input  logic       commit_i,
    output logic [7:0] nv_o,
    output logic       wel_o
);
    logic [7:0] nv_q;
    logic [7:0] pend_q;
    logic       wel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q   <= 8'h00;
            pend_q <= 8'h00;
            wel_q  <= 1'b0;
        end else begin
            if (load_i)
                pend_q <= load_data_i & SR_WR_MASK;
            if (commit_i)
                nv_q <= pend_q;
            if (wel_clr_i)
                wel_q <= 1'b0;
            else if (wel_set_i)
                wel_q <= 1'b1;
        end
    end

    assign nv_o  = nv_q & SR_WR_MASK;
    assign wel_o = wel_q;
endmodule

// File: rtl/sf_sr_timer.sv
module sf_sr_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic active_i,
    output logic expire_o
);
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = active_i && (cnt_q == '0);
endmodule

// File: rtl/sf_status_guard.sv
module sf_status_guard
    import sf_status_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int SR_WR_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              cmd_wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              cmd_prog_i,
    input  logic              cmd_sect_erase_i,
    input  logic              cmd_blk_erase_i,
    input  logic              cmd_chip_erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              array_done_i,
    output logic [7:0]        status_o,
    output logic              write_ok_o,
    output logic              sr_update_o
);
    fsm_state_t state_q, state_d;

    logic       idle, busy;
    logic       wel, hw_lock;
    logic [7:0] nv_image;
    logic [1:0] level;
    logic       addr_locked, all_locked;
    logic       addr_cmd;
    logic       accept_sr, accept_arr;
    logic       tmr_expire, arr_finish;
    logic       wel_set, wel_clr;
    logic       write_ok_q, sr_update_q;

    assign idle     = (state_q == ST_IDLE);
    assign busy     = !idle;
    assign level    = nv_image[SR_BP1:SR_BP0];
    assign hw_lock  = nv_image[SR_WPEN] && !wp_n_i;
    assign addr_cmd = cmd_prog_i || cmd_sect_erase_i || cmd_blk_erase_i;

    assign accept_sr  = idle && wel && cmd_wrsr_i && !hw_lock;
    assign accept_arr = idle && wel &&
                        ((addr_cmd && !addr_locked) ||
                         (cmd_chip_erase_i && !all_locked));

    assign arr_finish = (state_q == ST_ARRAY_OP) && array_done_i;
    assign wel_set    = idle && cmd_wren_i;
    assign wel_clr    = (idle && cmd_wrdi_i) || tmr_expire || arr_finish;

    sf_prot_check #(.ADDR_W(ADDR_W)) prot_i (
        .level_i       (level),
        .addr_i        (addr_i),
        .addr_locked_o (addr_locked),
        .all_locked_o  (all_locked)
    );

    sf_sr_bits bits_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wel_set_i   (wel_set),
        .wel_clr_i   (wel_clr),
        .load_i      (accept_sr),
        .load_data_i (wrsr_data_i),
        .commit_i    (tmr_expire),
        .nv_o        (nv_image),
        .wel_o       (wel)
    );

    sf_sr_timer #(.CYC(SR_WR_CYC)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept_sr),
        .active_i (state_q == ST_SR_WRITE),
        .expire_o (tmr_expire)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_sr)
                    state_d = ST_SR_WRITE;
                else if (accept_arr)
                    state_d = ST_ARRAY_OP;
            end
            ST_SR_WRITE: if (tmr_expire)   state_d = ST_IDLE;
            ST_ARRAY_OP: if (array_done_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // registered pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_ok_q  <= 1'b0;
            sr_update_q <= 1'b0;
        end else begin
            write_ok_q  <= accept_sr || accept_arr;
            sr_update_q <= tmr_expire;
        end
    end

    assign write_ok_o  = write_ok_q;
    assign sr_update_o = sr_update_q;
    assign status_o    = busy ? 8'hFF : (nv_image | {6'b0, wel, 1'b0});

    // R10: permission is a single-cycle pulse
    a_r10_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
        write_ok_o |=> !write_ok_o);

    // R4: no permission without the latch set in the strobe cycle
    a_r4_ok_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        write_ok_o |-> $past(wel));

    // R11: permission only follows an idle cycle
    a_r11_ok_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        write_ok_o |-> $past(state_q == ST_IDLE));

    // R9: new contents appear with the latch cleared and not busy
    a_r9_update_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        sr_update_o |-> (status_o[SR_WEL] == 1'b0 && status_o[SR_BUSY] == 1'b0));

    // R2: unused bits are zero whenever the byte is not busy
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[SR_BUSY] |-> (status_o[6:4] == 3'b000));

    // R7: pin plus protect-enable refuses a lone status write
    a_r7_hw_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_wrsr_i && hw_lock && !addr_cmd && !cmd_chip_erase_i)
        |=> !write_ok_o);
endmodule

// File: tb/sf_status_guard_tb_top.sv
`timescale 1ns/1ps
module sf_status_guard_tb_top;
    localparam int AW  = 17;
    localparam int SRC = 4;

    localparam logic [3:0] C_NOP = 4'd0, C_WREN = 4'd1, C_WRDI = 4'd2, C_WRSR = 4'd3,
                           C_PROG = 4'd4, C_SERA = 4'd5, C_BERA = 4'd6, C_CERA = 4'd7;

    // {cmd, addr, data, wp_n, status right after, ok, status after settling}
    localparam int VW = 4 + AW + 8 + 1 + 8 + 1 + 8;
    localparam int NV = 26;
    localparam logic [VW-1:0] VECS [0:NV-1] = '{
        {C_PROG, 17'h00000, 8'h00, 1'b1, 8'h00, 1'b0, 8'h00}, // R4
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h02, 1'b0, 8'h02}, // R3
        {C_WRDI, 17'h00000, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00}, // R3 pin low
        {C_WREN, 17'h00000, 8'h00, 1'b0, 8'h02, 1'b0, 8'h02}, // R3
        {C_WRSR, 17'h00000, 8'hF7, 1'b1, 8'hFF, 1'b1, 8'h84}, // R8
        {C_PROG, 17'h18000, 8'h00, 1'b1, 8'h84, 1'b0, 8'h84}, // R4
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h86, 1'b0, 8'h86},
        {C_PROG, 17'h18000, 8'h00, 1'b1, 8'h86, 1'b0, 8'h86}, // R5 quarter
        {C_PROG, 17'h17FFF, 8'h00, 1'b1, 8'hFF, 1'b1, 8'h84}, // R5 R10
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h86, 1'b0, 8'h86},
        {C_WRSR, 17'h00000, 8'h00, 1'b0, 8'h86, 1'b0, 8'h86}, // R7
        {C_WRSR, 17'h00000, 8'h08, 1'b1, 8'hFF, 1'b1, 8'h08}, // R7 pin high
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h0A, 1'b0, 8'h0A},
        {C_SERA, 17'h10000, 8'h00, 1'b1, 8'h0A, 1'b0, 8'h0A}, // R5 half
        {C_BERA, 17'h0FFFF, 8'h00, 1'b1, 8'hFF, 1'b1, 8'h08}, // R5
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h0A, 1'b0, 8'h0A},
        {C_CERA, 17'h00000, 8'h00, 1'b1, 8'hFF, 1'b1, 8'h08}, // R6 level 10
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h0A, 1'b0, 8'h0A},
        {C_WRSR, 17'h00000, 8'h0C, 1'b1, 8'hFF, 1'b1, 8'h0C},
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h0E, 1'b0, 8'h0E},
        {C_CERA, 17'h00000, 8'h00, 1'b1, 8'h0E, 1'b0, 8'h0E}, // R6 level 11
        {C_PROG, 17'h00000, 8'h00, 1'b1, 8'h0E, 1'b0, 8'h0E}, // R5 all
        {C_WRSR, 17'h00000, 8'h00, 1'b0, 8'hFF, 1'b1, 8'h00}, // R7 wpen 0
        {C_WREN, 17'h00000, 8'h00, 1'b1, 8'h02, 1'b0, 8'h02},
        {C_PROG, 17'h1FFFF, 8'h00, 1'b1, 8'hFF, 1'b1, 8'h00}, // R5 level 00
        {C_WRDI, 17'h00000, 8'h00, 1'b1, 8'h00, 1'b0, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          s_wren = 0, s_wrdi = 0, s_wrsr = 0, s_prog = 0;
    logic          s_sera = 0, s_bera = 0, s_cera = 0, done = 0;
    logic [7:0]    wdata = 8'h00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status;
    logic          write_ok, sr_update;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sf_status_guard #(.ADDR_W(AW), .SR_WR_CYC(SRC)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .wp_n_i           (wp_n),
        .cmd_wren_i       (s_wren),
        .cmd_wrdi_i       (s_wrdi),
        .cmd_wrsr_i       (s_wrsr),
        .wrsr_data_i      (wdata),
        .cmd_prog_i       (s_prog),
        .cmd_sect_erase_i (s_sera),
        .cmd_blk_erase_i  (s_bera),
        .cmd_chip_erase_i (s_cera),
        .addr_i           (addr),
        .array_done_i     (done),
        .status_o         (status),
        .write_ok_o       (write_ok),
        .sr_update_o      (sr_update)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] cmd, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic wp);
        @(negedge clk);
        wp_n = wp; addr = a; wdata = d;
        s_wren = (cmd == C_WREN); s_wrdi = (cmd == C_WRDI);
        s_wrsr = (cmd == C_WRSR); s_prog = (cmd == C_PROG);
        s_sera = (cmd == C_SERA); s_bera = (cmd == C_BERA);
        s_cera = (cmd == C_CERA);
        @(negedge clk);
        {s_wren, s_wrdi, s_wrsr, s_prog, s_sera, s_bera, s_cera} = '0;
    endtask

    task automatic finish_array();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        logic [VW-1:0] v;
        logic [3:0]    vc;
        logic [7:0]    v_now, v_after;
        logic          v_ok;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", status, 8'h00);
        check("R1 write_ok", {7'b0, write_ok}, 8'h00);
        check("R1 sr_update", {7'b0, sr_update}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", status, 8'h00);

        for (int i = 0; i < NV; i++) begin
            v       = VECS[i];
            vc      = v[VW-1 -: 4];
            v_now   = v[16:9];
            v_ok    = v[8];
            v_after = v[7:0];
            pulse(vc, v[VW-5 -: AW], v[VW-5-AW -: 8], v[17]);
            check($sformatf("R2 R3 R4 R5 vec%0d status", i), status, v_now);
            check($sformatf("R4 R5 R6 R7 vec%0d ok", i), {7'b0, write_ok}, {7'b0, v_ok});
            if (v_ok) begin
                if (vc == C_WRSR) repeat (SRC) @(negedge clk);
                else finish_array();
            end
            check($sformatf("R8 R10 vec%0d settled", i), status, v_after);
        end

        // R9 status write timing, pin falling mid-cycle
        pulse(C_WREN, '0, 8'h00, 1'b1);
        pulse(C_WRSR, '0, 8'h80, 1'b1);
        check("R9 busy c1", status, 8'hFF);
        check("R9 no update c1", {7'b0, sr_update}, 8'h00);
        wp_n = 1'b0;
        for (int k = 2; k <= SRC; k++) begin
            @(negedge clk);
            check("R9 busy window", status, 8'hFF);
            check("R9 no early update", {7'b0, sr_update}, 8'h00);
        end
        @(negedge clk);
        check("R9 new value", status, 8'h80);
        check("R9 update pulse", {7'b0, sr_update}, 8'h01);
        @(negedge clk);
        check("R9 update ends", {7'b0, sr_update}, 8'h00);

        // R7 now locked by pin plus protect-enable
        pulse(C_WREN, '0, 8'h00, 1'b0);
        pulse(C_WRSR, '0, 8'h00, 1'b0);
        check("R7 refused ok", {7'b0, write_ok}, 8'h00);
        check("R7 refused status", status, 8'h82);
        pulse(C_WRSR, '0, 8'h00, 1'b1);
        repeat (SRC) @(negedge clk);
        check("R7 pin high unlocks", status, 8'h00);

        // R11 commands ignored while busy
        pulse(C_WREN, '0, 8'h00, 1'b1);
        pulse(C_PROG, '0, 8'h00, 1'b1);
        check("R10 accepted", {7'b0, write_ok}, 8'h01);
        pulse(C_WRSR, '0, 8'h0C, 1'b1);
        check("R11 no ok while busy", {7'b0, write_ok}, 8'h00);
        check("R11 busy reads ones", status, 8'hFF);
        pulse(C_PROG, '0, 8'h00, 1'b1);
        check("R11 second prog ignored", {7'b0, write_ok}, 8'h00);
        finish_array();
        check("R10 wel cleared", status, 8'h00);
        repeat (SRC + 2) @(negedge clk);
        check("R11 contents unaltered", status, 8'h00);
        check("R11 no update", {7'b0, sr_update}, 8'h00);

        finished = 1;
        summary();
    end
endmodule